// File: doc/BRIEF.md
# Shift and Rotate Unit

This block computes the result of the shift group of R-type integer instructions for a 32-bit RISC pipeline. It receives the six-bit function code, the rt operand (the value being shifted), the rs operand and the five-bit sa field. It also receives one select bit that turns the two logical-right-shift codes into rotate-right operations. It produces the shifted or rotated word and raises an illegal flag for function codes that are not part of the group.

All six operations share one rotator of log2(width) stages. Left shifts are done by reversing the bits before the rotator and after the mask. Right shifts and sign fill use a mask derived from the shift amount. Because of this, no path ever shifts by the full word width.

A thin registered stage captures the result on every cycle where `in_valid` is high. This lets the result be checked cycle by cycle. The pipeline that owns the block drives the select bit. For the immediate rotate it takes instruction bit 21, and for the variable rotate it takes instruction bit 6.

Top module: `shift_rotate_unit`

## Requirements
- R1: Function code 0 returns rt shifted left logically by sa, with zeros filling the low bits.
- R2: Function code 2 with `rot_sel`=0 returns rt shifted right logically by sa. Code 6 with `rot_sel`=0 does the same by rs[4:0]. Zeros fill the high bits.
- R3: Function codes 3 (by sa) and 7 (by rs[4:0]) shift rt right arithmetically, filling the vacated high bits with rt[31].
- R4: Function codes 2 (by sa) and 6 (by rs[4:0]) with `rot_sel`=1 rotate rt right, so that result bit i equals rt bit (i+n) mod 32.
- R5: The register-amount codes 4, 6 and 7 take the amount only from rs[4:0]; rs[31:5] and sa have no effect on them. The immediate codes 0, 2 and 3 ignore rs completely.
- R6: With a shift amount of 0, every one of the six legal operations returns rt unchanged.
- R7: Function code 4 returns rt shifted left logically by rs[4:0].
- R8: Every function code other than 0, 2, 3, 4, 6 and 7 gives `illegal`=1 and a result of 0. This includes codes 1 and 5 and any code with bits 5:3 not zero. The legal codes give `illegal`=0.
- R9: Inputs present at a rising edge with `in_valid`=1 appear on `result` and `illegal` after that edge, with `out_valid`=1. A cycle with `in_valid`=0 leaves `out_valid`=0 after the next edge.
- R10: While `in_valid`=0, `result` and `illegal` hold their previous values whatever the other inputs do.
- R11: While reset is active, and until the first captured operation after it, `result`=0, `illegal`=0 and `out_valid`=0. Reset is asserted asynchronously and released through a two-flop synchronizer.
- R12: `rot_sel` has no effect on function codes 0, 3, 4 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture enable for the operation on the inputs |
| funct | input | 6 | R-type function code |
| rt_val | input | 32 | Operand to be shifted |
| rs_val | input | 32 | Operand whose bits 4:0 give the variable amount |
| sa | input | 5 | Immediate shift amount |
| rot_sel | input | 1 | Selects rotate instead of logical right shift for codes 2 and 6 |
| result | output | 32 | Registered result |
| illegal | output | 1 | Registered illegal-code flag |
| out_valid | output | 1 | Result registered from a valid input on the last edge |

## Verification
The bench runs each operation at amounts 0, 1, 31 and values in between. A design that shifts by 32 to form the rotate, or that masks wrongly at the ends, would return zero or a corrupted word at amount 0 or 31.

It uses negative and positive rt for the arithmetic shifts. A design that fills with zero, or takes the sign from the wrong word, shows it there.

It sets the unused rs bits, sa and `rot_sel` to misleading values. An amount source that is swapped or too wide, or a rotate select that leaks into other codes, then changes the result.

Codes 1, 5 and values above 7 must give zero with the flag raised. The hold and latency tests expose a capture enable that is ignored or an output that is registered one stage too many.

// File: rtl/sru_pkg.sv
package sru_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned AMT_W  = $clog2(DATA_W);

  localparam logic [5:0] FN_SLL_IMM = 6'd0;
  localparam logic [5:0] FN_SRL_IMM = 6'd2;
  localparam logic [5:0] FN_SRA_IMM = 6'd3;
  localparam logic [5:0] FN_SLL_VAR = 6'd4;
  localparam logic [5:0] FN_SRL_VAR = 6'd6;
  localparam logic [5:0] FN_SRA_VAR = 6'd7;

  typedef enum logic [2:0] {
    OPK_NONE = 3'd0,
    OPK_SLL  = 3'd1,
    OPK_SRL  = 3'd2,
    OPK_SRA  = 3'd3,
    OPK_ROR  = 3'd4
  } op_kind_e;
endpackage

// File: rtl/sru_decode.sv
module sru_decode
  import sru_pkg::*;
(
  input  logic [5:0] funct,
  input  logic       rot_sel,
  output op_kind_e   op_kind,
  output logic       use_var,
  output logic       legal
);
  always_comb begin
    op_kind = OPK_NONE;
    use_var = 1'b0;
    case (funct)
      FN_SLL_IMM: op_kind = OPK_SLL;
      FN_SRL_IMM: op_kind = rot_sel ? OPK_ROR : OPK_SRL;
      FN_SRA_IMM: op_kind = OPK_SRA;
      FN_SLL_VAR: begin op_kind = OPK_SLL; use_var = 1'b1; end
      FN_SRL_VAR: begin op_kind = rot_sel ? OPK_ROR : OPK_SRL; use_var = 1'b1; end
      FN_SRA_VAR: begin op_kind = OPK_SRA; use_var = 1'b1; end
      default:    op_kind = OPK_NONE;
    endcase
    legal = (op_kind != OPK_NONE);
  end
endmodule

// File: rtl/sru_rotator.sv
module sru_rotator #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AW-1:0]    amt,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [0:AW];

  assign stage[0] = din;

  // Stage k rotates right by 2**k when amount bit k is set.
  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int unsigned STEP = 2 ** k;
    assign stage[k+1] = amt[k] ? {stage[k][STEP-1:0], stage[k][WIDTH-1:STEP]}
                               : stage[k];
  end

  assign dout = stage[AW];
endmodule

// File: rtl/sru_mask.sv
module sru_mask #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW   = $clog2(WIDTH),
  localparam int unsigned SW   = AW + 1
) (
  input  logic [AW-1:0]    amt,
  output logic [WIDTH-1:0] keep
);
  // keep[j] is set when bit j still holds shifted data after a right shift by amt.
  for (genvar j = 0; j < WIDTH; j++) begin : g_bit
    assign keep[j] = (SW'(j) + {1'b0, amt}) < SW'(WIDTH);
  end
endmodule

// File: rtl/sru_core.sv
module sru_core
  import sru_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W,
  localparam int unsigned AW   = $clog2(WIDTH)
) (
  input  logic [5:0]       funct,
  input  logic [WIDTH-1:0] rt_val,
  input  logic [AW-1:0]    rs_amt,
  input  logic [AW-1:0]    sa,
  input  logic             rot_sel,
  output logic [WIDTH-1:0] res,
  output logic             illegal,
  output op_kind_e         op_kind,
  output logic [AW-1:0]    amt
);
  logic             use_var;
  logic             legal;
  logic [WIDTH-1:0] rt_rev;
  logic [WIDTH-1:0] rot_in;
  logic [WIDTH-1:0] rot_out;
  logic [WIDTH-1:0] keep;
  logic [WIDTH-1:0] srl_val;
  logic [WIDTH-1:0] sra_val;
  logic [WIDTH-1:0] sll_val;

  sru_decode u_dec (
    .funct   (funct),
    .rot_sel (rot_sel),
    .op_kind (op_kind),
    .use_var (use_var),
    .legal   (legal)
  );

  assign amt = use_var ? rs_amt : sa;

  for (genvar b = 0; b < WIDTH; b++) begin : g_rev
    assign rt_rev[b]  = rt_val[WIDTH-1-b];
    assign sll_val[b] = srl_val[WIDTH-1-b];
  end

  // A left shift is a right shift of the bit-reversed operand.
  assign rot_in = (op_kind == OPK_SLL) ? rt_rev : rt_val;

  sru_rotator #(.WIDTH(WIDTH)) u_rot (
    .din  (rot_in),
    .amt  (amt),
    .dout (rot_out)
  );

  sru_mask #(.WIDTH(WIDTH)) u_mask (
    .amt  (amt),
    .keep (keep)
  );

  assign srl_val = rot_out & keep;
  assign sra_val = srl_val | (~keep & {WIDTH{rt_val[WIDTH-1]}});

  always_comb begin
    case (op_kind)
      OPK_SLL: res = sll_val;
      OPK_SRL: res = srl_val;
      OPK_SRA: res = sra_val;
      OPK_ROR: res = rot_out;
      default: res = '0;
    endcase
    illegal = ~legal;
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W,
  localparam int unsigned AW   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [5:0]       funct,
  input  logic [WIDTH-1:0] rt_val,
  input  logic [WIDTH-1:0] rs_val,
  input  logic [AW-1:0]    sa,
  input  logic             rot_sel,
  output logic [WIDTH-1:0] result,
  output logic             illegal,
  output logic             out_valid
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [WIDTH-1:0] core_res;
  logic             core_ill;
  op_kind_e         core_op;
  logic [AW-1:0]    core_amt;
  logic [WIDTH-1:0] res_d,  res_q;
  logic             ill_d,  ill_q;
  logic             vld_d,  vld_q;
  logic             rs_high_unused;

  assign rs_high_unused = ^rs_val[WIDTH-1:AW];

  // Reset: asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sru_core #(.WIDTH(WIDTH)) u_core (
    .funct   (funct),
    .rt_val  (rt_val),
    .rs_amt  (rs_val[AW-1:0]),
    .sa      (sa),
    .rot_sel (rot_sel),
    .res     (core_res),
    .illegal (core_ill),
    .op_kind (core_op),
    .amt     (core_amt)
  );

  // Next-state logic with explicit capture enable.
  always_comb begin
    res_d = res_q;
    ill_d = ill_q;
    vld_d = in_valid;
    if (in_valid) begin
      res_d = core_res;
      ill_d = core_ill;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      ill_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      ill_q <= ill_d;
      vld_q <= vld_d;
    end
  end

  assign result    = res_q;
  assign illegal   = ill_q;
  assign out_valid = vld_q;

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ill_q |-> (res_q == '0)); // R8

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> vld_q); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(res_q) && $stable(ill_q))); // R10

  AST_SRA_SIGN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && core_op == OPK_SRA && rt_val[WIDTH-1]) |=> res_q[WIDTH-1]); // R3

  AST_ROT_ONES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && core_op == OPK_ROR) |=> ($countones(res_q) == $countones($past(rt_val)))); // R4

  AST_ZERO_AMT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !core_ill && core_amt == '0) |=> (res_q == $past(rt_val))); // R6
endmodule

// File: tb/shift_rotate_unit_tb.sv
`timescale 1ns/1ps
module shift_rotate_unit_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [5:0]  funct;
  logic [31:0] rt_val;
  logic [31:0] rs_val;
  logic [4:0]  sa;
  logic        rot_sel;
  logic [31:0] result;
  logic        illegal;
  logic        out_valid;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  shift_rotate_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .funct(funct),
    .rt_val(rt_val), .rs_val(rs_val), .sa(sa), .rot_sel(rot_sel),
    .result(result), .illegal(illegal), .out_valid(out_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit exp_ill(input logic [5:0] f);
    return !(f == 6'd0 || f == 6'd2 || f == 6'd3 || f == 6'd4 || f == 6'd6 || f == 6'd7);
  endfunction

  function automatic logic [31:0] exp_res(input logic [5:0] f, input logic [31:0] t,
                                          input logic [31:0] s, input logic [4:0] a_imm,
                                          input logic sel);
    int n;
    logic [31:0] r;
    n = f[2] ? int'(s[4:0]) : int'(a_imm);
    r = '0;
    case (f)
      6'd0, 6'd4: for (int i = 0; i < 32; i++) r[i] = (i >= n) ? t[i-n] : 1'b0;
      6'd2, 6'd6: for (int i = 0; i < 32; i++)
                    r[i] = sel ? t[(i+n)%32] : ((i + n < 32) ? t[i+n] : 1'b0);
      6'd3, 6'd7: for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? t[i+n] : t[31];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [5:0] f, input logic [31:0] t,
                        input logic [31:0] s, input logic [4:0] a, input logic sel);
    @(negedge clk);
    in_valid = 1'b1; funct = f; rt_val = t; rs_val = s; sa = a; rot_sel = sel;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    check({tag, " result"}, result, exp_res(f, t, s, a, sel));
    check({tag, " illegal"}, {31'd0, illegal}, {31'd0, exp_ill(f)});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; funct = '0; rt_val = '0; rs_val = '0; sa = '0; rot_sel = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset result", result, 32'h0);
    check("R11 reset flags", {30'd0, illegal, out_valid}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R11 after release", {illegal, out_valid, result[29:0]}, 32'h0);
  endtask

  task automatic t_left_imm;   // R1
    run_op("R1 sll 4",  6'd0, 32'h8000_00F1, 32'hFFFF_FFFF, 5'd4,  1'b0);
    run_op("R1 sll 31", 6'd0, 32'h0000_0003, 32'h0,         5'd31, 1'b0);
  endtask

  task automatic t_right_logical; // R2
    run_op("R2 srl imm 1",  6'd2, 32'hF000_0001, 32'h0,      5'd1,  1'b0);
    run_op("R2 srl var 31", 6'd6, 32'h8000_0000, 32'd31,     5'd3,  1'b0);
    run_op("R2 srl var 8",  6'd6, 32'hDEAD_BEEF, 32'd8,      5'd0,  1'b0);
  endtask

  task automatic t_arith;      // R3
    run_op("R3 sra imm neg", 6'd3, 32'h8765_4321, 32'h0,   5'd12, 1'b0);
    run_op("R3 sra imm pos", 6'd3, 32'h7765_4321, 32'h0,   5'd31, 1'b0);
    run_op("R3 sra var neg", 6'd7, 32'hFFFF_0000, 32'd31,  5'd0,  1'b0);
    run_op("R3 sra var pos", 6'd7, 32'h4000_0000, 32'd5,   5'd0,  1'b0);
  endtask

  task automatic t_rotate;     // R4
    run_op("R4 ror imm 1",  6'd2, 32'h0000_0001, 32'h0,   5'd1,  1'b1);
    run_op("R4 ror imm 31", 6'd2, 32'h8000_0001, 32'h0,   5'd31, 1'b1);
    run_op("R4 ror var 16", 6'd6, 32'h1234_5678, 32'd16,  5'd7,  1'b1);
    run_op("R4 ror var 5",  6'd6, 32'hA5A5_0F0F, 32'd5,   5'd0,  1'b1);
  endtask

  task automatic t_amount_source; // R5
    run_op("R5 var ignores rs high", 6'd4, 32'h0000_00FF, 32'hFFFF_FFE3, 5'd17, 1'b0);
    run_op("R5 var ignores sa",      6'd7, 32'h8000_0000, 32'h0000_0002, 5'd30, 1'b0);
    run_op("R5 imm ignores rs",      6'd2, 32'hFF00_FF00, 32'h0000_001F, 5'd4,  1'b0);
  endtask

  task automatic t_zero_amount; // R6
    run_op("R6 sll 0", 6'd0, 32'hCAFE_F00D, 32'h0,         5'd0, 1'b0);
    run_op("R6 srl 0", 6'd2, 32'hCAFE_F00D, 32'h0,         5'd0, 1'b0);
    run_op("R6 sra 0", 6'd7, 32'hCAFE_F00D, 32'hFFFF_FFE0, 5'd9, 1'b0);
    run_op("R6 ror 0", 6'd6, 32'hCAFE_F00D, 32'h0000_0020, 5'd3, 1'b1);
    run_op("R6 ror imm 0", 6'd2, 32'h8000_0001, 32'h0,     5'd0, 1'b1);
  endtask

  task automatic t_left_var;   // R7
    run_op("R7 sllv 1",  6'd4, 32'h8000_0001, 32'd1,  5'd0, 1'b0);
    run_op("R7 sllv 31", 6'd4, 32'hFFFF_FFFF, 32'd31, 5'd0, 1'b0);
  endtask

  task automatic t_illegal;    // R8
    run_op("R8 code 1",  6'd1,  32'hFFFF_FFFF, 32'd3, 5'd3, 1'b1);
    run_op("R8 code 5",  6'd5,  32'h1234_5678, 32'd3, 5'd3, 1'b0);
    run_op("R8 code 8",  6'd8,  32'h1234_5678, 32'd3, 5'd3, 1'b0);
    run_op("R8 code 34", 6'd34, 32'h1234_5678, 32'd3, 5'd3, 1'b1);
    run_op("R8 legal clears", 6'd0, 32'h1, 32'd0, 5'd2, 1'b0);
  endtask

  task automatic t_latency;    // R9
    @(negedge clk);
    in_valid = 1'b1; funct = 6'd0; rt_val = 32'h1; rs_val = '0; sa = 5'd3; rot_sel = 1'b0;
    @(posedge clk);
    #1;
    check("R9 valid after edge", {31'd0, out_valid}, 32'd1);
    check("R9 result after one edge", result, 32'h8);
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    check("R9 valid drops", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_hold;       // R10
    run_op("R10 setup", 6'd5, 32'h5, 32'h0, 5'd1, 1'b0);
    @(negedge clk);
    funct = 6'd0; rt_val = 32'hFFFF_FFFF; sa = 5'd1; rs_val = 32'h7;
    repeat (2) @(posedge clk);
    #1;
    check("R10 result held", result, 32'h0);
    check("R10 illegal held", {31'd0, illegal}, 32'd1);
    run_op("R10 setup2", 6'd2, 32'h10, 32'h0, 5'd4, 1'b0);
    @(negedge clk);
    funct = 6'd1; rt_val = 32'h0; rot_sel = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R10 legal result held", result, 32'h1);
    check("R10 flag held low", {31'd0, illegal}, 32'd0);
  endtask

  task automatic t_sel_ignored; // R12
    run_op("R12 sll sel", 6'd0, 32'h8000_0003, 32'h0,  5'd1, 1'b1);
    run_op("R12 sra sel", 6'd3, 32'h8000_0003, 32'h0,  5'd1, 1'b1);
    run_op("R12 sllv sel", 6'd4, 32'h8000_0003, 32'd2, 5'd0, 1'b1);
    run_op("R12 srav sel", 6'd7, 32'h0000_0003, 32'd1, 5'd0, 1'b1);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_left_imm();
    t_right_logical();
    t_arith();
    t_rotate();
    t_amount_source();
    t_zero_amount();
    t_left_var();
    t_illegal();
    t_latency();
    t_hold();
    t_sel_ignored();
    finish_run();
  end
endmodule